// File: doc/BRIEF.md
# Hashed Page Table Search Engine

This block translates the page part of a 32-bit effective address through a hashed page table held in external memory. The top four address bits pick one of sixteen segment words. Each segment word supplies a 24-bit segment identifier, two protection-key selectors, a no-execute flag and a direct-store flag. For an ordinary segment the block hashes the segment identifier with the 16-bit page index to find a group of eight two-word entries and reads that group one word at a time. If no entry in the group hits, it reads a second group found from the complemented hash.

When an entry hits, the block decodes the page protection under the access key and sets the referenced bit. A permitted write also sets the changed bit. The second word of the entry goes back to memory only when one of these bits actually changes. The result is a 20-bit real page number, read and write permission flags and a status code, all presented with a single-cycle done pulse. A processor's miss handler would drive a request here and install the returned page into its translation cache. The segment words and the table base register must stay stable while a search runs. Memory answers each read one cycle after the request.

Top module: `hpt_search`

## Requirements
- R1: A segment word with bit 31 set returns status 4 (direct-store) without any memory access. This check takes precedence over the no-execute check.
- R2: An instruction fetch (is_fetch=1) through a segment word with bit 28 set returns status 3 (no-execute) without any memory access. A fetch through a segment without bit 28 is translated normally.
- R3: The first search uses hash H = ((VSID xor PI) and 0x7FFFF) << 6, where VSID is segment bits 23:0 and PI is address bits 27:12. The group address is (base and 0xFFFF0000) or (H and ((base[8:0] << 16) or 0xFFC0)). Entry i occupies words at group+8i and group+8i+4. A hit returns status 0 and the real page number from word 1 bits 31:12.
- R4: An entry hits only when word 0 bit 31 is 1, word 0 bit 6 equals the pass (0 first, 1 second), and word 0 with bits 31 and 6 cleared equals (VSID << 7) or (PI >> 10). When the first group has no hit, the second group is searched using hash (not H) and 0x01FFFFC0. A full pass reads 16 words.
- R5: When neither group holds a hit, the status is 1 (no-match).
- R6: The access key is 1 when segment bit 29 is set and user_mode=1, or when segment bit 30 is set and user_mode=0. Otherwise the key is 0.
- R7: The protection field is word 1 bits 1:0. Under key 0, read is always allowed and write is allowed unless the field is 3. Under key 1, field 0 allows nothing, fields 1 and 3 allow read only, and field 2 allows read and write. A hit whose requested access is not allowed returns status 2 (protection) with the decoded flags.
- R8: On a hit, word 1 bit 8 (referenced) is set. The updated word 1 is written to group+8i+4 only if it differs from the stored word, and nothing is written otherwise.
- R9: Word 1 bit 7 (changed) is set only by a permitted write. perm_wr is reported as 0 whenever the changed bit remains clear after the access.
- R10: When two or more entries hit and their word 1 values differ under mask 0xFFFFF07B, the status is 5 (conflict) and nothing is written. Entries that differ only outside that mask count as one hit on the lowest-numbered entry.
- R11: done is high for exactly one cycle per request. A read and a write are never issued in the same cycle.
- R12: After reset, done, mem_rd_en, mem_wr_en, perm_rd and perm_wr are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request strobe, accepted when idle |
| va_page | input | 20 | Effective address bits 31:12 |
| is_write | input | 1 | Request is a store |
| is_fetch | input | 1 | Request is an instruction fetch |
| user_mode | input | 1 | Request comes from user mode |
| seg_flat | input | 512 | Sixteen 32-bit segment words, word k at bits 32k+31:32k |
| table_base | input | 32 | Page table base and hash mask extension |
| mem_rd_en | output | 1 | Memory read request |
| mem_wr_en | output | 1 | Memory write request |
| mem_addr | output | 32 | Byte address of the accessed word |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after mem_rd_en |
| done | output | 1 | Result valid pulse |
| status | output | 3 | 0 hit, 1 no-match, 2 protection, 3 no-execute, 4 direct-store, 5 conflict |
| rpn | output | 20 | Real page number |
| perm_rd | output | 1 | Read permitted |
| perm_wr | output | 1 | Write permitted |

## Verification
On the last entry of a group, the entry evaluation and the decision for the whole pass happen in the same cycle. The search must then choose between reporting a conflict, starting the reference and changed update, switching to the second group, or giving up. The bench places hits in slot 7 of the second group, and also places two matching entries, once with word 1 values that differ and once with values that differ only in ignored bits. It judges the outcome by the status, the number of reads and writes counted at the memory port, and the final memory contents. A permitted first write falls in the same cycle as the changed-bit update that governs perm_wr. That case is checked by comparing perm_wr with the written-back word.

// File: rtl/hpt_pkg.sv
package hpt_pkg;

    localparam int NUM_SEGS     = 16;
    localparam int SEG_SEL_W    = $clog2(NUM_SEGS);
    localparam int PTEG_ENTRIES = 8;
    localparam int IDX_W        = $clog2(PTEG_ENTRIES);
    localparam int ENTRY_SHIFT  = 3;
    localparam int GRP_ALIGN    = IDX_W + ENTRY_SHIFT;
    localparam int WORD_W       = 32;
    localparam int VSID_W       = 24;
    localparam int PIDX_W       = 16;
    localparam int RPN_W        = 20;

    localparam logic [31:0] HASH_KEEP    = 32'h0007_FFFF;
    localparam logic [31:0] SEC_HASH_MSK = 32'h01FF_FFC0;
    localparam logic [31:0] CMP_MASK     = 32'h7FFF_FFBF;
    localparam logic [31:0] CONSIST_MASK = 32'hFFFF_F07B;
    localparam int REF_BIT = 8;
    localparam int CHG_BIT = 7;

    typedef enum logic [2:0] {
        ST_HIT      = 3'd0,
        ST_NOMATCH  = 3'd1,
        ST_PROT     = 3'd2,
        ST_NOEXEC   = 3'd3,
        ST_DIRECT   = 3'd4,
        ST_CONFLICT = 3'd5
    } hpt_status_e;

    typedef enum logic [2:0] {
        S_IDLE, S_CHK, S_REQ0, S_GET0, S_GET1, S_WB
    } hpt_state_e;

    typedef struct packed {
        logic rd;
        logic wr;
    } hpt_perm_t;

    function automatic hpt_perm_t decode_perm(input logic key, input logic [1:0] pp);
        hpt_perm_t p;
        if (!key) begin
            p.rd = 1'b1;
            p.wr = (pp != 2'd3);
        end else begin
            case (pp)
                2'd0:    begin p.rd = 1'b0; p.wr = 1'b0; end
                2'd2:    begin p.rd = 1'b1; p.wr = 1'b1; end
                default: begin p.rd = 1'b1; p.wr = 1'b0; end
            endcase
        end
        return p;
    endfunction

    function automatic logic [31:0] first_hash(input logic [VSID_W-1:0] vsid,
                                               input logic [PIDX_W-1:0] pidx);
        logic [31:0] mix;
        mix = {{(32-VSID_W){1'b0}}, vsid} ^ {{(32-PIDX_W){1'b0}}, pidx};
        return (mix & HASH_KEEP) << GRP_ALIGN;
    endfunction

    function automatic logic [31:0] group_base(input logic [31:0] base,
                                               input logic [31:0] hash);
        logic [31:0] msk;
        msk = {7'd0, base[8:0], 16'hFFC0};
        return {base[31:16], 16'h0000} | (hash & msk);
    endfunction

endpackage

// File: rtl/hpt_addr_gen.sv
module hpt_addr_gen
    import hpt_pkg::*;
(
    input  logic [RPN_W-1:0]           va_page,
    input  logic [NUM_SEGS*WORD_W-1:0] seg_flat,
    input  logic [WORD_W-1:0]          table_base,
    input  logic                       user_mode,
    input  logic                       pass,
    output logic                       seg_direct,
    output logic                       seg_noexec,
    output logic                       key,
    output logic [WORD_W-1:0]          grp_addr,
    output logic [WORD_W-1:0]          cmp_word
);
    logic [WORD_W-1:0] segs [NUM_SEGS];

    for (genvar g = 0; g < NUM_SEGS; g++) begin : g_seg
        assign segs[g] = seg_flat[g*WORD_W +: WORD_W];
    end

    logic [WORD_W-1:0]    seg;
    logic [VSID_W-1:0]    vsid;
    logic [PIDX_W-1:0]    pidx;
    logic [WORD_W-1:0]    h_first;
    logic [WORD_W-1:0]    h_second;

    assign seg        = segs[va_page[RPN_W-1 -: SEG_SEL_W]];
    assign vsid       = seg[VSID_W-1:0];
    assign pidx       = va_page[PIDX_W-1:0];
    assign seg_direct = seg[31];
    assign seg_noexec = seg[28];
    assign key        = (seg[29] && user_mode) || (seg[30] && !user_mode);

    assign h_first  = first_hash(vsid, pidx);
    assign h_second = ~h_first & SEC_HASH_MSK;
    assign grp_addr = group_base(table_base, pass ? h_second : h_first);
    assign cmp_word = {1'b0, vsid, 1'b0, pidx[PIDX_W-1 -: 6]};
endmodule

// File: rtl/hpt_pte_eval.sv
module hpt_pte_eval
    import hpt_pkg::*;
(
    input  logic [WORD_W-1:0] w0,
    input  logic [WORD_W-1:0] w1,
    input  logic [WORD_W-1:0] keep,
    input  logic [WORD_W-1:0] cmp_word,
    input  logic              pass,
    output logic              match,
    output logic              differs
);
    assign match   = w0[31] && (w0[6] == pass) && ((w0 & CMP_MASK) == cmp_word);
    assign differs = ((keep ^ w1) & CONSIST_MASK) != '0;
endmodule

// File: rtl/hpt_search.sv
module hpt_search
    import hpt_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       start,
    input  logic [19:0]                va_page,
    input  logic                       is_write,
    input  logic                       is_fetch,
    input  logic                       user_mode,
    input  logic [511:0]               seg_flat,
    input  logic [31:0]                table_base,
    output logic                       mem_rd_en,
    output logic                       mem_wr_en,
    output logic [31:0]                mem_addr,
    output logic [31:0]                mem_wdata,
    input  logic [31:0]                mem_rdata,
    output logic                       done,
    output logic [2:0]                 status,
    output logic [19:0]                rpn,
    output logic                       perm_rd,
    output logic                       perm_wr
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PTEG_ENTRIES - 1);

    hpt_state_e        state_q;
    hpt_status_e       status_q;
    logic [RPN_W-1:0]  page_q;
    logic              wr_q, fetch_q, user_q, pass_q;
    logic [IDX_W-1:0]  idx_q, hit_idx_q, nhit_idx;
    logic              found_q, conflict_q, nfound, nconflict;
    logic [WORD_W-1:0] keep_q, nkeep, w0_q, wb_q, upd_word;
    logic              done_q, prd_q, pwr_q;
    logic [RPN_W-1:0]  rpn_q;

    logic              seg_direct, seg_noexec, key, match, differs;
    logic [WORD_W-1:0] grp_addr, cmp_word;
    hpt_perm_t         perm;
    logic              granted, new_chg;

    hpt_addr_gen u_addr (
        .va_page   (page_q),
        .seg_flat  (seg_flat),
        .table_base(table_base),
        .user_mode (user_q),
        .pass      (pass_q),
        .seg_direct(seg_direct),
        .seg_noexec(seg_noexec),
        .key       (key),
        .grp_addr  (grp_addr),
        .cmp_word  (cmp_word)
    );

    hpt_pte_eval u_eval (
        .w0      (w0_q),
        .w1      (mem_rdata),
        .keep    (keep_q),
        .cmp_word(cmp_word),
        .pass    (pass_q),
        .match   (match),
        .differs (differs)
    );

    // Running result of the group scan including the entry seen this cycle
    always_comb begin
        nfound    = found_q;
        nkeep     = keep_q;
        nhit_idx  = hit_idx_q;
        nconflict = conflict_q;
        if (state_q == S_GET1 && match) begin
            if (!found_q) begin
                nfound   = 1'b1;
                nkeep    = mem_rdata;
                nhit_idx = idx_q;
            end else if (differs) begin
                nconflict = 1'b1;
            end
        end
        perm     = decode_perm(key, nkeep[1:0]);
        granted  = wr_q ? perm.wr : perm.rd;
        new_chg  = nkeep[CHG_BIT] | (wr_q & granted);
        upd_word = nkeep;
        upd_word[REF_BIT] = 1'b1;
        upd_word[CHG_BIT] = new_chg;
    end

    always_comb begin
        mem_rd_en = (state_q == S_REQ0) || (state_q == S_GET0);
        mem_wr_en = (state_q == S_WB);
        mem_wdata = wb_q;
        case (state_q)
            S_REQ0:  mem_addr = grp_addr | {{(WORD_W-GRP_ALIGN){1'b0}}, idx_q, 3'b000};
            S_GET0:  mem_addr = grp_addr | {{(WORD_W-GRP_ALIGN){1'b0}}, idx_q, 3'b100};
            S_WB:    mem_addr = grp_addr | {{(WORD_W-GRP_ALIGN){1'b0}}, hit_idx_q, 3'b100};
            default: mem_addr = grp_addr;
        endcase
    end

    always_ff @(posedge clk) begin
        done_q <= 1'b0;
        if (rst) begin
            state_q    <= S_IDLE;
            status_q   <= ST_NOMATCH;
            page_q     <= '0;
            wr_q       <= 1'b0;
            fetch_q    <= 1'b0;
            user_q     <= 1'b0;
            pass_q     <= 1'b0;
            idx_q      <= '0;
            hit_idx_q  <= '0;
            found_q    <= 1'b0;
            conflict_q <= 1'b0;
            keep_q     <= '0;
            w0_q       <= '0;
            wb_q       <= '0;
            rpn_q      <= '0;
            prd_q      <= 1'b0;
            pwr_q      <= 1'b0;
        end else begin
            case (state_q)
                S_IDLE: if (start) begin
                    page_q  <= va_page;
                    wr_q    <= is_write;
                    fetch_q <= is_fetch;
                    user_q  <= user_mode;
                    pass_q  <= 1'b0;
                    state_q <= S_CHK;
                end
                S_CHK: begin
                    idx_q      <= '0;
                    found_q    <= 1'b0;
                    conflict_q <= 1'b0;
                    rpn_q      <= '0;
                    prd_q      <= 1'b0;
                    pwr_q      <= 1'b0;
                    if (seg_direct) begin
                        status_q <= ST_DIRECT;
                        done_q   <= 1'b1;
                        state_q  <= S_IDLE;
                    end else if (fetch_q && seg_noexec) begin
                        status_q <= ST_NOEXEC;
                        done_q   <= 1'b1;
                        state_q  <= S_IDLE;
                    end else begin
                        state_q <= S_REQ0;
                    end
                end
                S_REQ0: state_q <= S_GET0;
                S_GET0: begin
                    w0_q    <= mem_rdata;
                    state_q <= S_GET1;
                end
                S_GET1: begin
                    found_q    <= nfound;
                    keep_q     <= nkeep;
                    hit_idx_q  <= nhit_idx;
                    conflict_q <= nconflict;
                    if (idx_q != LAST_IDX) begin
                        idx_q   <= idx_q + 1'b1;
                        state_q <= S_REQ0;
                    end else if (nconflict) begin
                        status_q <= ST_CONFLICT;
                        done_q   <= 1'b1;
                        state_q  <= S_IDLE;
                    end else if (nfound) begin
                        status_q <= granted ? ST_HIT : ST_PROT;
                        rpn_q    <= nkeep[WORD_W-1 -: RPN_W];
                        prd_q    <= perm.rd;
                        pwr_q    <= perm.wr & new_chg;
                        wb_q     <= upd_word;
                        if (upd_word != nkeep) begin
                            state_q <= S_WB;
                        end else begin
                            done_q  <= 1'b1;
                            state_q <= S_IDLE;
                        end
                    end else if (!pass_q) begin
                        pass_q  <= 1'b1;
                        idx_q   <= '0;
                        state_q <= S_REQ0;
                    end else begin
                        status_q <= ST_NOMATCH;
                        done_q   <= 1'b1;
                        state_q  <= S_IDLE;
                    end
                end
                S_WB: begin
                    done_q  <= 1'b1;
                    state_q <= S_IDLE;
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    assign done    = done_q;
    assign status  = status_q;
    assign rpn     = rpn_q;
    assign perm_rd = prd_q;
    assign perm_wr = pwr_q;

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);                                                   // R11
    AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd_en && mem_wr_en));                                        // R11
    AST_WB_WORD1: assert property (@(posedge clk) disable iff (rst)
        mem_wr_en |-> mem_addr[2:0] == 3'b100);                            // R8
    AST_WB_REF_SET: assert property (@(posedge clk) disable iff (rst)
        mem_wr_en |-> mem_wdata[REF_BIT]);                                 // R8
    AST_DIRECT_NO_READ: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_CHK && seg_direct) |=> (!mem_rd_en && done));        // R1
    AST_WRITE_HIT_PERM: assert property (@(posedge clk) disable iff (rst)
        (done && status == ST_HIT && wr_q) |-> perm_wr);                   // R9
endmodule

// File: tb/tb_hpt_search.sv
module tb_hpt_search;
    localparam logic [31:0] TBASE = 32'h00A0_0003;

    typedef struct packed {
        logic [31:0] seg;
        logic [31:0] ea;
        logic        wr, fetch, user, place, sec, h;
        logic [2:0]  slot;
        logic [1:0]  pp;
        logic [1:0]  rc;
        logic [2:0]  st;
        logic        erd, ewr, ewb, ec;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{32'h0000_0123, 32'h3456_7000, 1'b0,1'b0,1'b0,1'b1,1'b0,1'b0, 3'd0, 2'd2, 2'b00, 3'd0, 1'b1,1'b0,1'b1,1'b0},
        '{32'h0000_0123, 32'h3456_7000, 1'b1,1'b0,1'b0,1'b1,1'b0,1'b0, 3'd5, 2'd2, 2'b00, 3'd0, 1'b1,1'b1,1'b1,1'b1},
        '{32'h0000_0123, 32'h3456_7000, 1'b1,1'b0,1'b0,1'b1,1'b0,1'b0, 3'd2, 2'd3, 2'b00, 3'd2, 1'b1,1'b0,1'b1,1'b0},
        '{32'h2000_0123, 32'h3456_7000, 1'b0,1'b0,1'b1,1'b1,1'b0,1'b0, 3'd3, 2'd0, 2'b00, 3'd2, 1'b0,1'b0,1'b1,1'b0},
        '{32'h2000_0123, 32'h3ABC_D000, 1'b1,1'b0,1'b1,1'b1,1'b1,1'b1, 3'd7, 2'd2, 2'b01, 3'd0, 1'b1,1'b1,1'b1,1'b1},
        '{32'h2000_0123, 32'h3456_7000, 1'b0,1'b0,1'b1,1'b1,1'b0,1'b0, 3'd1, 2'd1, 2'b00, 3'd0, 1'b1,1'b0,1'b1,1'b0},
        '{32'h4000_0456, 32'h7000_1000, 1'b1,1'b0,1'b0,1'b1,1'b0,1'b0, 3'd6, 2'd3, 2'b00, 3'd2, 1'b1,1'b0,1'b1,1'b0},
        '{32'h0000_0123, 32'h3456_7000, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 3'd0, 2'd0, 2'b00, 3'd1, 1'b0,1'b0,1'b0,1'b0},
        '{32'h8000_0123, 32'h3456_7000, 1'b0,1'b0,1'b0,1'b1,1'b0,1'b0, 3'd0, 2'd2, 2'b00, 3'd4, 1'b0,1'b0,1'b0,1'b0},
        '{32'h1000_0123, 32'h5000_0000, 1'b0,1'b1,1'b0,1'b1,1'b0,1'b0, 3'd0, 2'd2, 2'b00, 3'd3, 1'b0,1'b0,1'b0,1'b0},
        '{32'h0000_0123, 32'h5000_0000, 1'b0,1'b1,1'b0,1'b1,1'b0,1'b0, 3'd4, 2'd2, 2'b00, 3'd0, 1'b1,1'b0,1'b1,1'b0},
        '{32'h0000_0123, 32'h3456_7000, 1'b0,1'b0,1'b0,1'b1,1'b0,1'b1, 3'd2, 2'd2, 2'b00, 3'd1, 1'b0,1'b0,1'b0,1'b0},
        '{32'h0000_0123, 32'h3456_7000, 1'b1,1'b0,1'b0,1'b1,1'b0,1'b0, 3'd3, 2'd2, 2'b11, 3'd0, 1'b1,1'b1,1'b0,1'b1},
        '{32'h0000_0123, 32'h3456_7000, 1'b0,1'b0,1'b0,1'b1,1'b1,1'b0, 3'd2, 2'd2, 2'b00, 3'd1, 1'b0,1'b0,1'b0,1'b0},
        '{32'h2000_0123, 32'h3456_7000, 1'b1,1'b0,1'b0,1'b1,1'b0,1'b0, 3'd0, 2'd0, 2'b00, 3'd0, 1'b1,1'b1,1'b1,1'b1}
    };

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [19:0]  va_page = '0;
    logic         is_write = 1'b0, is_fetch = 1'b0, user_mode = 1'b0;
    logic [511:0] seg_flat = '0;
    logic         mem_rd_en, mem_wr_en, done, perm_rd, perm_wr;
    logic [31:0]  mem_addr, mem_wdata;
    logic [31:0]  mem_rdata = '0;
    logic [2:0]   status;
    logic [19:0]  rpn;

    int n_checks = 0, n_fail = 0, rd_cnt = 0, wr_cnt = 0;
    logic [31:0] mem [int unsigned];

    always #2.5 clk = ~clk;

    hpt_search dut (
        .clk(clk), .rst(rst), .start(start), .va_page(va_page),
        .is_write(is_write), .is_fetch(is_fetch), .user_mode(user_mode),
        .seg_flat(seg_flat), .table_base(TBASE),
        .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .done(done),
        .status(status), .rpn(rpn), .perm_rd(perm_rd), .perm_wr(perm_wr)
    );

    always @(posedge clk) begin
        if (mem_rd_en) begin
            mem_rdata <= mem.exists(mem_addr) ? mem[mem_addr] : 32'h0;
            rd_cnt = rd_cnt + 1;
        end
        if (mem_wr_en) begin
            mem[mem_addr] = mem_wdata;
            wr_cnt = wr_cnt + 1;
        end
    end

    function automatic logic [31:0] rd_mem(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    function automatic logic [31:0] grp_of(input logic [31:0] seg, input logic [31:0] ea,
                                           input logic sec);
        logic [31:0] h;
        h = ((({8'h0, seg[23:0]}) ^ ({16'h0, ea[27:12]})) & 32'h0007_FFFF) << 6;
        if (sec) h = ~h & 32'h01FF_FFC0;
        return (TBASE & 32'hFFFF_0000) | (h & ({7'h0, TBASE[8:0], 16'h0} | 32'h0000_FFC0));
    endfunction

    function automatic logic [31:0] w0_of(input logic [31:0] seg, input logic [31:0] ea,
                                          input logic h);
        return 32'h8000_0000 | ({8'h0, seg[23:0]} << 7) | ({31'h0, h} << 6) | {26'h0, ea[27:22]};
    endfunction

    task automatic put(input logic [31:0] seg, input logic [31:0] ea, input logic sec,
                       input logic h, input int slot, input logic [31:0] w1);
        logic [31:0] a;
        a = grp_of(seg, ea, sec) + 32'(slot * 8);
        mem[a]     = w0_of(seg, ea, h);
        mem[a + 4] = w1;
    endtask

    task automatic check(input logic ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic run(input logic [31:0] seg, input logic [31:0] ea, input logic w,
                       input logic f, input logic u);
        int cyc;
        @(negedge clk);
        seg_flat = '0;
        seg_flat[int'(ea[31:28])*32 +: 32] = seg;
        va_page = ea[31:12]; is_write = w; is_fetch = f; user_mode = u;
        rd_cnt = 0; wr_cnt = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        while (!done && cyc < 500) begin
            @(negedge clk);
            cyc++;
        end
        check(done, "R11 done seen", {31'h0, done}, 32'h1);
    endtask

    task automatic check_pulse_end();
        @(negedge clk);
        check(!done, "R11 done one cycle", {31'h0, done}, 32'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [19:0] erpn;
        logic [31:0] w1, exp_w1, a1;
        int exp_rd;
        string tag;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12 reset state
        check(!done && !mem_rd_en && !mem_wr_en, "R12 reset outputs",
              {29'h0, done, mem_rd_en, mem_wr_en}, 32'h0);
        check(!perm_rd && !perm_wr, "R12 reset perms", {30'h0, perm_rd, perm_wr}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            mem.delete();
            erpn = 20'h4A000 + 20'(i);
            w1 = {erpn, 3'b000, VECS[i].rc[1], VECS[i].rc[0], 5'b00000, VECS[i].pp};
            if (VECS[i].place)
                put(VECS[i].seg, VECS[i].ea, VECS[i].sec, VECS[i].h, int'(VECS[i].slot), w1);
            run(VECS[i].seg, VECS[i].ea, VECS[i].wr, VECS[i].fetch, VECS[i].user);
            case (VECS[i].st)
                3'd0: tag = "R3 hit status";
                3'd1: tag = "R5 no-match status";
                3'd2: tag = "R7 protection status";
                3'd3: tag = "R2 no-execute status";
                3'd4: tag = "R1 direct-store status";
                default: tag = "R10 conflict status";
            endcase
            check(status == VECS[i].st, tag, {29'h0, status}, {29'h0, VECS[i].st});
            if (VECS[i].st == 3'd0 || VECS[i].st == 3'd2)
                check(perm_rd == VECS[i].erd && perm_wr == VECS[i].ewr, "R6 R7 R9 permission flags",
                      {30'h0, perm_rd, perm_wr}, {30'h0, VECS[i].erd, VECS[i].ewr});
            if (VECS[i].st == 3'd0)
                check(rpn == erpn, "R3 real page number", {12'h0, rpn}, {12'h0, erpn});
            check(wr_cnt == int'(VECS[i].ewb), "R8 write-back count", 32'(wr_cnt), {31'h0, VECS[i].ewb});
            if (VECS[i].st == 3'd3 || VECS[i].st == 3'd4) exp_rd = 0;
            else if (VECS[i].st == 3'd1 || VECS[i].sec) exp_rd = 32;
            else exp_rd = 16;
            check(rd_cnt == exp_rd, "R4 memory read count", 32'(rd_cnt), 32'(exp_rd));
            if (VECS[i].place) begin
                a1 = grp_of(VECS[i].seg, VECS[i].ea, VECS[i].sec) + 32'(int'(VECS[i].slot) * 8) + 4;
                if (VECS[i].st == 3'd0 || VECS[i].st == 3'd2)
                    exp_w1 = {erpn, 3'b000, 1'b1, VECS[i].ec, 5'b00000, VECS[i].pp};
                else
                    exp_w1 = w1;
                check(rd_mem(a1) == exp_w1, "R9 stored word 1", rd_mem(a1), exp_w1);
            end
            check_pulse_end();
        end

        // R10: two matches whose word 1 differs in the real page number
        mem.delete();
        put(32'h0000_0123, 32'h3456_7000, 1'b0, 1'b0, 1, 32'h1111_1002);
        put(32'h0000_0123, 32'h3456_7000, 1'b0, 1'b0, 4, 32'h2222_2002);
        run(32'h0000_0123, 32'h3456_7000, 1'b0, 1'b0, 1'b0);
        check(status == 3'd5, "R10 conflicting duplicates", {29'h0, status}, 32'h5);
        check(wr_cnt == 0, "R10 no write on conflict", 32'(wr_cnt), 32'h0);
        check_pulse_end();

        // R10: duplicates differing only in the referenced bit count as one hit on slot 1
        mem.delete();
        put(32'h0000_0123, 32'h3456_7000, 1'b0, 1'b0, 1, 32'h1111_1002);
        put(32'h0000_0123, 32'h3456_7000, 1'b0, 1'b0, 4, 32'h1111_1102);
        run(32'h0000_0123, 32'h3456_7000, 1'b0, 1'b0, 1'b0);
        check(status == 3'd0, "R10 benign duplicates hit", {29'h0, status}, 32'h0);
        check(rpn == 20'h11111, "R10 duplicate rpn", {12'h0, rpn}, 32'h11111);
        a1 = grp_of(32'h0000_0123, 32'h3456_7000, 1'b0) + 32'd12;
        check(rd_mem(a1) == 32'h1111_1102, "R8 first slot updated", rd_mem(a1), 32'h1111_1102);
        check(wr_cnt == 1, "R8 single write-back", 32'(wr_cnt), 32'h1);
        check_pulse_end();

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule